// File: doc/BRIEF.md
# Fractional-N Feedback Divider Sequencer

The block drives the modulus-select line of a dual-modulus prescaler (divide by P or P+1) and produces the feedback pulse that goes to the phase-frequency detector. It is clocked by the prescaler output. Each feedback cycle lasts a programmed number of prescaler periods, INT. At the end of each cycle a first-order phase accumulator adds FRAC modulo MOD. When the accumulator overflows, the next cycle uses P+1 for its first prescaler period. Over MOD cycles, FRAC of them are stretched by one RF period. The average division is therefore INT·P + FRAC/MOD.

In the low-spur mode, the least significant bit of a 16-bit LFSR is added to the accumulator input at each cycle boundary. This breaks up the periodic carry patterns. The block has an asynchronous reset and two synchronous park controls: a counter hold and a power-down. Both park controls return every counter to its load state. A combinational flag reports any programming that is not legal.

Top module: `fracn_fb_ctrl`

## Requirements
- R1: While `rst_n` is low, `fb_pulse` and `mod_sel` are 0. After release, the block behaves as it does right after a park (R6).
- R2: A feedback cycle lasts L clocks, where L is the INT value sampled in the first clock of that cycle (clamped as in R11). `fb_pulse` is 1 only in the last clock of each cycle.
- R3: In the last clock of each cycle, with legal FRAC/MOD, the accumulator takes the value acc+FRAC(+dither). If that sum is at least MOD, MOD is subtracted and a carry is recorded. Without dither, MOD consecutive cycles produce exactly FRAC carries. FRAC = MOD produces a carry at every boundary.
- R4: `mod_sel` is 1 in exactly the first clock of a cycle whose preceding boundary produced a carry, and 0 in every other clock.
- R5: Dither is applied only when `ns_mode` = 3'b000 and FRAC < MOD. It adds bit 0 of an LFSR that is seeded to 16'hACE1. At each boundary the LFSR shifts left, and bits 15, 13, 12 and 10 are XORed into bit 0. In every other mode, including 3'b001 and 3'b111, nothing is added.
- R6: While `cnt_hold` is 1, both outputs are 0. The cycle counter and the accumulator are cleared, the carry is dropped and the LFSR is reseeded. After release, the first clock starts a fresh cycle with no carry.
- R7: `pwr_dn` has the same effect as `cnt_hold`.
- R8: A change of INT in the middle of a cycle does not alter the length of the running cycle. FRAC, MOD and the mode are used only in the last clock of a cycle.
- R9: `cfg_err` is 1 exactly when FRAC > MOD, MOD = 0 or INT < 4.
- R10: A boundary that sees FRAC > MOD or MOD = 0 leaves the accumulator unchanged and records no carry.
- R11: An INT value below 4 is treated as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| int_val | input | 8 | Prescaler periods per feedback cycle |
| frac_val | input | 12 | Fractional numerator |
| mod_val | input | 12 | Fractional modulus |
| ns_mode | input | 3 | Noise/spur mode; 000 enables dither |
| cnt_hold | input | 1 | Holds counters in their load state |
| pwr_dn | input | 1 | Power-down; parks counters like cnt_hold |
| mod_sel | output | 1 | 1 selects P+1 for the current prescaler period |
| fb_pulse | output | 1 | Feedback pulse to the PFD, last clock of a cycle |
| cfg_err | output | 1 | Illegal INT/FRAC/MOD programming |

## Verification
A park request can arrive in the same clock as a cycle boundary that would otherwise record a carry. The bench provokes this by raising `cnt_hold`, and separately `pwr_dn`, halfway through the clock in which `fb_pulse` is high, with FRAC = MOD so that a carry is certain. It then checks three things: `fb_pulse` drops within that clock, the accumulator result is discarded, and the first cycle after release shows no `mod_sel`. A change of INT that lands one clock after the sampling point is also checked, to confirm that the running cycle keeps its length.

// File: rtl/fracn_pkg.sv
`timescale 1ns/1ps
package fracn_pkg;
   typedef enum logic [2:0] {
      NS_LOW_SPUR       = 3'b000,
      NS_LOW_NOISE_SPUR = 3'b001,
      NS_LOW_NOISE      = 3'b111
   } ns_mode_e;

   function automatic logic dither_mode(input logic [2:0] mode);
      return mode == NS_LOW_SPUR;
   endfunction
endpackage

// File: rtl/fracn_cycle_cnt.sv
`timescale 1ns/1ps
module fracn_cycle_cnt #(
   parameter int INT_W   = 8,
   parameter int MIN_INT = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             park,
   input  logic [INT_W-1:0] int_in,
   output logic             first_o,
   output logic             wrap_o
);
   localparam logic [INT_W-1:0] MIN_LEN = INT_W'(MIN_INT);

   logic [INT_W-1:0] cnt_q, len_q, len_eff;
   logic             last;

   assign len_eff = (int_in < MIN_LEN) ? MIN_LEN : int_in;
   assign first_o = (cnt_q == '0);
   assign last    = !first_o && (cnt_q == len_q - 1'b1);
   assign wrap_o  = !park && last;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         len_q <= MIN_LEN;
      end else if (park) begin
         cnt_q <= '0;
         len_q <= len_eff;
      end else if (first_o) begin
         cnt_q <= 1'b1;
         len_q <= len_eff;
      end else if (last) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assert_cnt_in_cycle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !first_o |-> cnt_q < len_q);
   assert_len_clamped_R11: assert property (@(posedge clk) disable iff (!rst_n)
      len_q >= MIN_LEN);
   assert_len_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (!park && !first_o && !$past(first_o) && !$past(park)) |-> $stable(len_q));
endmodule

// File: rtl/fracn_dither.sv
`timescale 1ns/1ps
module fracn_dither #(
   parameter int          LFSR_W = 16,
   parameter logic [15:0] SEED   = 16'hACE1,
   parameter logic [15:0] TAPS   = 16'hB400,
   parameter bit          ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic park,
   input  logic step,
   output logic bit_o
);
   generate
      if (LFSR_W != 16) begin : g_bad_w
         $error("fracn_dither: LFSR_W must be 16");
      end
      if (ENABLE) begin : g_lfsr
         logic [LFSR_W-1:0] lfsr_q;
         logic              fb;
         assign fb    = ^(lfsr_q & TAPS);
         assign bit_o = lfsr_q[0];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     lfsr_q <= SEED;
            else if (park)  lfsr_q <= SEED;
            else if (step)  lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
         end
         assert_lfsr_live_R5: assert property (@(posedge clk) disable iff (!rst_n)
            lfsr_q != '0);
      end else begin : g_none
         logic unused_in;
         assign unused_in = ^{clk, rst_n, park, step};
         assign bit_o     = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/fracn_accum.sv
`timescale 1ns/1ps
module fracn_accum #(
   parameter int FRAC_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              park,
   input  logic              step,
   input  logic [FRAC_W-1:0] frac_i,
   input  logic [FRAC_W-1:0] mod_i,
   input  logic              dith_i,
   output logic              carry_o,
   output logic              bad_o
);
   localparam int SUM_W = FRAC_W + 2;

   logic [FRAC_W-1:0] acc_q;
   logic [SUM_W-1:0]  sum, wrapped;
   logic              dith_use, over;

   assign bad_o    = (frac_i > mod_i) || (mod_i == '0);
   assign dith_use = dith_i && (frac_i < mod_i);
   assign sum      = SUM_W'(acc_q) + SUM_W'(frac_i) + SUM_W'(dith_use);
   assign over     = sum >= SUM_W'(mod_i);
   assign wrapped  = sum - SUM_W'(mod_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q   <= '0;
         carry_o <= 1'b0;
      end else if (park) begin
         acc_q   <= '0;
         carry_o <= 1'b0;
      end else if (step) begin
         if (bad_o) begin
            carry_o <= 1'b0;
         end else if (over) begin
            acc_q   <= wrapped[FRAC_W-1:0];
            carry_o <= 1'b1;
         end else begin
            acc_q   <= sum[FRAC_W-1:0];
            carry_o <= 1'b0;
         end
      end
   end

   assert_acc_below_mod_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !park && !bad_o && acc_q < mod_i) |=> acc_q < $past(mod_i));
   assert_bad_no_carry_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !park && bad_o) |=> (!carry_o && $stable(acc_q)));
   assert_park_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
      park |=> (acc_q == '0 && !carry_o));
endmodule

// File: rtl/fracn_fb_ctrl.sv
`timescale 1ns/1ps
module fracn_fb_ctrl
   import fracn_pkg::*;
#(
   parameter int          INT_W     = 8,
   parameter int          FRAC_W    = 12,
   parameter int          MIN_INT   = 4,
   parameter int          LFSR_W    = 16,
   parameter logic [15:0] LFSR_SEED = 16'hACE1,
   parameter bit          DITHER_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [INT_W-1:0]  int_val,
   input  logic [FRAC_W-1:0] frac_val,
   input  logic [FRAC_W-1:0] mod_val,
   input  logic [2:0]        ns_mode,
   input  logic              cnt_hold,
   input  logic              pwr_dn,
   output logic              mod_sel,
   output logic              fb_pulse,
   output logic              cfg_err
);
   generate
      if (MIN_INT < 2 || MIN_INT >= (1 << INT_W)) begin : g_bad_min
         $error("fracn_fb_ctrl: MIN_INT out of range");
      end
      if (FRAC_W < 2) begin : g_bad_frac
         $error("fracn_fb_ctrl: FRAC_W too small");
      end
   endgenerate

   logic park, first, wrap, dbit, carry, bad_fm;

   assign park = cnt_hold || pwr_dn;

   fracn_cycle_cnt #(.INT_W(INT_W), .MIN_INT(MIN_INT)) u_cnt (
      .clk(clk), .rst_n(rst_n), .park(park), .int_in(int_val),
      .first_o(first), .wrap_o(wrap)
   );

   fracn_dither #(.LFSR_W(LFSR_W), .SEED(LFSR_SEED), .ENABLE(DITHER_EN)) u_dith (
      .clk(clk), .rst_n(rst_n), .park(park), .step(wrap), .bit_o(dbit)
   );

   fracn_accum #(.FRAC_W(FRAC_W)) u_acc (
      .clk(clk), .rst_n(rst_n), .park(park), .step(wrap),
      .frac_i(frac_val), .mod_i(mod_val),
      .dith_i(dbit && dither_mode(ns_mode)),
      .carry_o(carry), .bad_o(bad_fm)
   );

   assign fb_pulse = wrap;
   assign mod_sel  = !park && carry && first;
   assign cfg_err  = bad_fm || (int_val < INT_W'(MIN_INT));

   assert_sel_after_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mod_sel) |-> $past(fb_pulse));
   assert_park_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(park) |-> (!mod_sel && !fb_pulse));
   assert_sel_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      mod_sel |=> !mod_sel);
endmodule

// File: tb/tb_fracn_fb_ctrl.sv
`timescale 1ns/1ps
module tb_fracn_fb_ctrl;
   logic        clk = 1'b0, rst_n = 1'b0;
   logic [7:0]  int_val = 8'd5;
   logic [11:0] frac_val = '0, mod_val = 12'd10;
   logic [2:0]  ns_mode = 3'b001;
   logic        cnt_hold = 1'b0, pwr_dn = 1'b0;
   logic        mod_sel, fb_pulse, cfg_err;

   int n_chk = 0, n_bad = 0, n_fb = 0, n_ms = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   fracn_fb_ctrl dut (
      .clk(clk), .rst_n(rst_n), .int_val(int_val), .frac_val(frac_val),
      .mod_val(mod_val), .ns_mode(ns_mode), .cnt_hold(cnt_hold), .pwr_dn(pwr_dn),
      .mod_sel(mod_sel), .fb_pulse(fb_pulse), .cfg_err(cfg_err)
   );

   // Reference model built from the requirements
   logic [7:0]  m_cnt, m_len;
   logic [12:0] m_acc;
   logic        m_carry;
   logic [15:0] m_lfsr;

   function automatic logic [7:0] clamp4(input logic [7:0] v);
      return (v < 8'd4) ? 8'd4 : v;
   endfunction

   always @(posedge clk or negedge rst_n) begin
      if (!rst_n || cnt_hold || pwr_dn) begin
         m_cnt = 0; m_acc = 0; m_carry = 0; m_lfsr = 16'hACE1;
         m_len = rst_n ? clamp4(int_val) : 8'd4;
      end else if (m_cnt == 0) begin
         m_len = clamp4(int_val); m_cnt = 1;
      end else if (m_cnt == m_len - 1) begin
         if (frac_val > mod_val || mod_val == 0) begin
            m_carry = 0;
         end else begin
            logic [13:0] s;
            logic        d;
            d = (ns_mode == 3'b000 && frac_val < mod_val) ? m_lfsr[0] : 1'b0;
            s = 14'(m_acc) + 14'(frac_val) + 14'(d);
            if (s >= 14'(mod_val)) begin m_acc = 13'(s - 14'(mod_val)); m_carry = 1; end
            else begin m_acc = 13'(s); m_carry = 0; end
         end
         m_lfsr = {m_lfsr[14:0], m_lfsr[15] ^ m_lfsr[13] ^ m_lfsr[12] ^ m_lfsr[10]};
         m_cnt = 0;
      end else begin
         m_cnt = m_cnt + 1;
      end
   end

   task automatic check(input string tag, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   task automatic run(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         logic park, efb, ems, eerr;
         @(negedge clk);
         park = cnt_hold || pwr_dn;
         efb  = !park && rst_n && m_cnt != 0 && m_cnt == m_len - 1;
         ems  = !park && rst_n && m_carry && m_cnt == 0;
         eerr = frac_val > mod_val || mod_val == 0 || int_val < 8'd4;
         check(tag, "fb_pulse", fb_pulse, efb);
         check(tag, "mod_sel", mod_sel, ems);
         check("R9", "cfg_err", cfg_err, eerr);
         n_fb += fb_pulse;
         n_ms += mod_sel;
      end
   endtask

   task automatic setup(input logic [7:0] i, input logic [11:0] f, input logic [11:0] m,
                        input logic [2:0] md);
      @(posedge clk); #1;
      int_val = i; frac_val = f; mod_val = m; ns_mode = md; cnt_hold = 1'b1;
      @(posedge clk); #1;
      @(posedge clk); #1;
      cnt_hold = 1'b0; n_fb = 0; n_ms = 0;
   endtask

   task automatic t_reset();
      repeat (2) @(negedge clk);
      check("R1", "fb_pulse in reset", fb_pulse, 0);
      check("R1", "mod_sel in reset", mod_sel, 0);
      @(posedge clk); #1 rst_n = 1'b1;
      n_fb = 0; n_ms = 0;
      run(10, "R1");
      check("R1", "pulses after reset", n_fb, 2);
   endtask

   task automatic t_integer();
      setup(8'd5, 12'd0, 12'd10, 3'b001);
      run(30, "R2");
      check("R2", "pulse count INT=5", n_fb, 6);
      check("R2", "no P+1 with FRAC=0", n_ms, 0);
   endtask

   task automatic t_fraction();
      setup(8'd4, 12'd3, 12'd7, 3'b001);
      run(32, "R4");
      check("R3", "carries 3/7 over 7 boundaries", n_ms, 3);
      check("R2", "pulse count INT=4", n_fb, 8);
   endtask

   task automatic t_full();
      setup(8'd4, 12'd5, 12'd5, 3'b111);
      run(32, "R4");
      check("R3", "FRAC=MOD carries", n_ms, 7);
   endtask

   task automatic t_bad();
      setup(8'd4, 12'd9, 12'd5, 3'b001);
      run(24, "R10");
      check("R10", "no carry with FRAC>MOD", n_ms, 0);
      check("R9", "cfg_err FRAC>MOD", cfg_err, 1);
      setup(8'd4, 12'd0, 12'd0, 3'b001);
      run(8, "R10");
      check("R9", "cfg_err MOD=0", cfg_err, 1);
   endtask

   task automatic t_clamp();
      setup(8'd2, 12'd0, 12'd8, 3'b001);
      run(24, "R11");
      check("R11", "INT=2 runs as 4", n_fb, 6);
      check("R9", "cfg_err INT<4", cfg_err, 1);
   endtask

   task automatic t_update();
      setup(8'd5, 12'd0, 12'd8, 3'b001);
      run(1, "R8");
      @(posedge clk); #1 int_val = 8'd7;
      run(18, "R8");
      check("R8", "pulses 5+7+7", n_fb, 3);
      check("R8", "pulse on clock 19", fb_pulse, 1);
   endtask

   task automatic t_dither();
      setup(8'd4, 12'd0, 12'd2, 3'b000);
      run(64, "R5");
      check("R5", "dither gives carries with FRAC=0", int'(n_ms > 0), 1);
      setup(8'd4, 12'd0, 12'd2, 3'b001);
      run(64, "R5");
      check("R5", "mode 001 no dither", n_ms, 0);
      setup(8'd4, 12'd0, 12'd2, 3'b111);
      run(64, "R5");
      check("R5", "mode 111 no dither", n_ms, 0);
   endtask

   task automatic t_park_at_edge(input bit use_pd, input string tag);
      setup(8'd4, 12'd5, 12'd5, 3'b001);
      run(3, tag);
      @(negedge clk);
      check(tag, "boundary reached", fb_pulse, 1);
      if (use_pd) pwr_dn = 1'b1; else cnt_hold = 1'b1;
      #0.5;
      check(tag, "pulse dropped by park", fb_pulse, 0);
      @(posedge clk); #1;
      if (use_pd) pwr_dn = 1'b0; else cnt_hold = 1'b0;
      n_ms = 0; n_fb = 0;
      run(4, tag);
      check(tag, "no carry after park", n_ms, 0);
      check(tag, "fresh cycle length", n_fb, 1);
   endtask

   initial begin
      #750000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_integer();
      t_fraction();
      t_full();
      t_bad();
      t_clamp();
      t_update();
      t_dither();
      t_park_at_edge(1'b0, "R6");
      t_park_at_edge(1'b1, "R7");
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule